// File: doc/BRIEF.md
# Windowed Multi-Channel Alarm Monitor

This block supervises up to four converter channels. A prescaler paces a round-robin scan and raises a one-cycle conversion-start request that names the next channel to convert. The pace is set by a 3-bit delay code. Each step of the code doubles the interval between requests, so code 7 scans 128 times slower than code 0.

When the converter returns a 12-bit result tagged with its channel, the block compares the result against that channel's lower and upper limits. A result outside the window latches an alarm bit for the channel. The bit stays set until software pulses that channel's clear input. One special limit pair turns the check off for a channel: the lower limit at the most negative two's-complement code and the upper limit at the most positive.

The four alarm bits are always visible on a status output. An open-drain style interrupt is formed from an output enable and a data line that is tied low. The enable is asserted only while interrupts are enabled and at least one alarm is latched.

Top module: `win_mon_top`

## Requirements
- R1: While reset is high and on the first cycle after it, all alarm bits read 0, the interrupt enable output is 0 and no conversion-start request is issued.
- R2: Conversion-start requests are one cycle wide and spaced exactly BASE_PERIOD << delay_code clock cycles apart (8, 32 and 1024 cycles for codes 0, 2 and 7 at the default BASE_PERIOD of 8).
- R3: Successive requests name channels 0, 1, ... up to the programmed last channel, then wrap to channel 0, starting from channel 0 after reset.
- R4: A result whose unsigned value is below the channel's lower limit sets that channel's alarm bit (bit n of the status for channel n) on the clock edge that accepts the result.
- R5: A result above the channel's upper limit sets its alarm bit. A result equal to either limit does not set it.
- R6: A set alarm bit stays set when later in-window results arrive for that channel.
- R7: A clear pulse on one channel resets that channel's alarm bit on the next edge and leaves the other channels' bits untouched.
- R8: A clear pulse and an out-of-window result for the same channel in the same cycle leave the alarm bit set.
- R9: With lower limit 0x800 and upper limit 0x7FF a channel never raises an alarm, whatever the result.
- R10: The interrupt output enable is high exactly when interrupts are enabled and at least one alarm bit is set. The interrupt data line is always 0.
- R11: Alarms latch and show on the status output while interrupts are disabled.
- R12: A result presented without the conversion-done strobe, or tagged with another channel, does not change a channel's alarm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| delay_code | input | 3 | Scan interval exponent |
| irq_en | input | 1 | Interrupt enable |
| lo_thr | input | 48 | Lower limits, channel n at bits 12n+11:12n |
| hi_thr | input | 48 | Upper limits, channel n at bits 12n+11:12n |
| alarm_clr | input | 4 | Per-channel alarm clear pulses |
| conv_done | input | 1 | Conversion result valid strobe |
| conv_chan | input | 2 | Channel of the presented result |
| conv_data | input | 12 | Conversion result |
| chan_last | input | 2 | Highest channel in the scan |
| conv_start | output | 1 | Conversion-start request pulse |
| start_chan | output | 2 | Channel to convert with the request |
| alarm_status | output | 4 | Latched alarm bits |
| irq_oe | output | 1 | Interrupt output enable (drive low when 1) |
| irq_data | output | 1 | Interrupt data line, constant 0 |

## Verification
The bench probes results that sit exactly on each limit. A design that used inclusive comparison would raise false alarms there. It drives the disable pair with both extreme codes, which catches a design that compares unsigned without the special case. It issues a clear pulse in the same cycle as a violation on the same channel; letting the clear win there would lose an event. It also times the request spacing at three delay codes and follows the wrap of the channel pointer with a shortened scan set, where an off-by-one in the terminal count or in the wrap shows up as a wrong interval or a skipped or extra channel.

// File: rtl/win_mon_pkg.sv
package win_mon_pkg;

    localparam int MON_DW  = 12;
    localparam int MON_NCH = 4;
    localparam int MON_CHW = 2;

    typedef logic [MON_DW-1:0]  sample_t;
    typedef logic [MON_CHW-1:0] chan_t;

    typedef struct packed {
        sample_t lo;
        sample_t hi;
    } window_t;

    typedef struct packed {
        logic    valid;
        chan_t   chan;
        sample_t data;
    } result_t;

    localparam sample_t OFF_LO = {1'b1, {(MON_DW-1){1'b0}}};
    localparam sample_t OFF_HI = {1'b0, {(MON_DW-1){1'b1}}};

    function automatic logic window_off(input window_t w);
        return (w.lo == OFF_LO) && (w.hi == OFF_HI);
    endfunction

    function automatic logic window_violation(input sample_t d, input window_t w);
        return !window_off(w) && ((d < w.lo) || (d > w.hi));
    endfunction

    function automatic chan_t rr_next(input chan_t cur, input chan_t last);
        return (cur >= last) ? chan_t'(0) : chan_t'(cur + 1'b1);
    endfunction

endpackage

// File: rtl/mon_scan_timer.sv
module mon_scan_timer
    import win_mon_pkg::*;
#(
    parameter int BASE_PERIOD = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] delay_code,
    input  chan_t      chan_last,
    output logic       conv_start,
    output chan_t      start_chan
);
    localparam int MAX_PERIOD = BASE_PERIOD * 128;
    localparam int CW = $clog2(MAX_PERIOD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] term;
    chan_t         ptr;
    chan_t         cur;
    logic          tick;

    always_comb begin
        term = CW'((BASE_PERIOD << delay_code) - 1);
        tick = (cnt >= term);
        cur  = (ptr > chan_last) ? chan_t'(0) : ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ptr <= '0;
        end else if (tick) begin
            cnt <= '0;
            ptr <= rr_next(cur, chan_last);
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign conv_start = tick && !rst;
    assign start_chan = cur;

endmodule

// File: rtl/mon_alarm_cell.sv
module mon_alarm_cell
    import win_mon_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sample_vld,
    input  sample_t sample,
    input  window_t win,
    input  logic    clr,
    output logic    alarm
);
    logic hit;

    always_comb hit = sample_vld && window_violation(sample, win);

    always_ff @(posedge clk) begin
        if (rst)
            alarm <= 1'b0;
        else
            alarm <= (alarm && !clr) || hit;
    end

endmodule

// File: rtl/mon_alarm_bank.sv
module mon_alarm_bank
    import win_mon_pkg::*;
#(
    parameter int NCH = MON_NCH
) (
    input  logic           clk,
    input  logic           rst,
    input  result_t        res,
    input  window_t        win [NCH],
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] alarm
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        always_comb sel = res.valid && (res.chan == chan_t'(i));

        mon_alarm_cell cell_i (
            .clk        (clk),
            .rst        (rst),
            .sample_vld (sel),
            .sample     (res.data),
            .win        (win[i]),
            .clr        (clr[i]),
            .alarm      (alarm[i])
        );
    end

endmodule

// File: rtl/mon_irq_drive.sv
module mon_irq_drive #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] alarm,
    input  logic           irq_en,
    output logic           irq_oe,
    output logic           irq_data
);
    always_comb begin
        irq_oe   = irq_en && (|alarm);
        irq_data = 1'b0;
    end

endmodule

// File: rtl/win_mon_top.sv
module win_mon_top
    import win_mon_pkg::*;
#(
    parameter int NCH         = MON_NCH,
    parameter int BASE_PERIOD = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            delay_code,
    input  logic                  irq_en,
    input  logic [NCH*MON_DW-1:0] lo_thr,
    input  logic [NCH*MON_DW-1:0] hi_thr,
    input  logic [NCH-1:0]        alarm_clr,
    input  logic                  conv_done,
    input  logic [MON_CHW-1:0]    conv_chan,
    input  logic [MON_DW-1:0]     conv_data,
    input  logic [MON_CHW-1:0]    chan_last,
    output logic                  conv_start,
    output logic [MON_CHW-1:0]    start_chan,
    output logic [NCH-1:0]        alarm_status,
    output logic                  irq_oe,
    output logic                  irq_data
);
    window_t win [NCH];
    result_t res;

    for (genvar i = 0; i < NCH; i++) begin : g_win
        assign win[i].lo = lo_thr[i*MON_DW +: MON_DW];
        assign win[i].hi = hi_thr[i*MON_DW +: MON_DW];
    end

    always_comb begin
        res.valid = conv_done;
        res.chan  = conv_chan;
        res.data  = conv_data;
    end

    mon_scan_timer #(.BASE_PERIOD(BASE_PERIOD)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .delay_code (delay_code),
        .chan_last  (chan_last),
        .conv_start (conv_start),
        .start_chan (start_chan)
    );

    mon_alarm_bank #(.NCH(NCH)) bank_i (
        .clk   (clk),
        .rst   (rst),
        .res   (res),
        .win   (win),
        .clr   (alarm_clr),
        .alarm (alarm_status)
    );

    mon_irq_drive #(.NCH(NCH)) irq_i (
        .alarm    (alarm_status),
        .irq_en   (irq_en),
        .irq_oe   (irq_oe),
        .irq_data (irq_data)
    );

endmodule

// File: rtl/win_mon_chk.sv
module win_mon_chk
    import win_mon_pkg::*;
#(
    parameter int NCH         = MON_NCH,
    parameter int BASE_PERIOD = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  irq_en,
    input logic [NCH*MON_DW-1:0] lo_thr,
    input logic [NCH*MON_DW-1:0] hi_thr,
    input logic [NCH-1:0]        alarm_clr,
    input logic                  conv_done,
    input logic [MON_CHW-1:0]    conv_chan,
    input logic [MON_CHW-1:0]    chan_last,
    input logic                  conv_start,
    input logic [MON_CHW-1:0]    start_chan,
    input logic [NCH-1:0]        alarm_status,
    input logic                  irq_oe,
    input logic                  irq_data
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (alarm_status == '0));

    // R2
    if (BASE_PERIOD > 1) begin : g_pulse
        start_single_chk: assert property (@(posedge clk) disable iff (rst)
            conv_start |=> !conv_start);
    end

    // R3
    start_in_set_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (start_chan <= chan_last));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_en || alarm_status == '0) |-> !irq_oe);

    // R10
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        irq_oe |-> (irq_data == 1'b0));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic own_res;
        logic off_pair;
        assign own_res  = conv_done && (conv_chan == MON_CHW'(i));
        assign off_pair = (lo_thr[i*MON_DW +: MON_DW] == OFF_LO) &&
                          (hi_thr[i*MON_DW +: MON_DW] == OFF_HI);

        // R6
        sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (alarm_status[i] && !alarm_clr[i]) |=> alarm_status[i]);

        // R7
        clear_chk: assert property (@(posedge clk) disable iff (rst)
            (alarm_clr[i] && !own_res) |=> !alarm_status[i]);

        // R9
        off_pair_chk: assert property (@(posedge clk) disable iff (rst)
            (!alarm_status[i] && off_pair) |=> !alarm_status[i]);

        // R12
        foreign_chk: assert property (@(posedge clk) disable iff (rst)
            (!own_res && !alarm_clr[i]) |=> $stable(alarm_status[i]));
    end

endmodule

bind win_mon_top win_mon_chk #(.NCH(NCH), .BASE_PERIOD(BASE_PERIOD)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .irq_en       (irq_en),
    .lo_thr       (lo_thr),
    .hi_thr       (hi_thr),
    .alarm_clr    (alarm_clr),
    .conv_done    (conv_done),
    .conv_chan    (conv_chan),
    .chan_last    (chan_last),
    .conv_start   (conv_start),
    .start_chan   (start_chan),
    .alarm_status (alarm_status),
    .irq_oe       (irq_oe),
    .irq_data     (irq_data)
);

// File: tb/win_mon_top_tb_top.sv
module win_mon_top_tb_top;
    localparam int NCH = 4;
    localparam int DW  = 12;
    localparam int NV  = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      delay_code = 3'd0;
    logic            irq_en = 1'b0;
    logic [NCH*DW-1:0] lo_thr = '0;
    logic [NCH*DW-1:0] hi_thr = '1;
    logic [NCH-1:0]  alarm_clr = '0;
    logic            conv_done = 1'b0;
    logic [1:0]      conv_chan = '0;
    logic [DW-1:0]   conv_data = '0;
    logic [1:0]      chan_last = 2'd3;
    logic            conv_start;
    logic [1:0]      start_chan;
    logic [NCH-1:0]  alarm_status;
    logic            irq_oe;
    logic            irq_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    win_mon_top dut_i (
        .clk(clk), .rst(rst), .delay_code(delay_code), .irq_en(irq_en),
        .lo_thr(lo_thr), .hi_thr(hi_thr), .alarm_clr(alarm_clr),
        .conv_done(conv_done), .conv_chan(conv_chan), .conv_data(conv_data),
        .chan_last(chan_last), .conv_start(conv_start), .start_chan(start_chan),
        .alarm_status(alarm_status), .irq_oe(irq_oe), .irq_data(irq_data)
    );

    // chan, data, lo, hi, clear, expected status
    localparam logic [45:0] VECS [NV] = '{
        {2'd0, 12'h100, 12'h200, 12'hE00, 4'h0, 4'h1},  // R4 below
        {2'd1, 12'hF00, 12'h200, 12'hE00, 4'h0, 4'h3},  // R5 above
        {2'd2, 12'h200, 12'h200, 12'hE00, 4'h0, 4'h3},  // R5 equal lower
        {2'd2, 12'hE00, 12'h200, 12'hE00, 4'h0, 4'h3},  // R5 equal upper
        {2'd0, 12'h500, 12'h200, 12'hE00, 4'h0, 4'h3},  // R6 sticky
        {2'd3, 12'h000, 12'h800, 12'h7FF, 4'h0, 4'h3},  // R9 off pair low
        {2'd3, 12'hFFF, 12'h800, 12'h7FF, 4'h0, 4'h3},  // R9 off pair high
        {2'd2, 12'h500, 12'h200, 12'hE00, 4'h1, 4'h2},  // R7 clear one
        {2'd1, 12'hF00, 12'h200, 12'hE00, 4'h2, 4'h2},  // R8 clear vs hit
        {2'd2, 12'h100, 12'h200, 12'hE00, 4'h2, 4'h4},  // R4 hit, R7 clear
        {2'd3, 12'h000, 12'h010, 12'h7FF, 4'h0, 4'hC},  // R4 not off pair
        {2'd0, 12'h900, 12'h800, 12'h7FF, 4'hC, 4'h0}   // R9 and R7
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic present(input logic [1:0] ch, input logic [DW-1:0] d,
                           input logic vld, input logic [NCH-1:0] clr);
        conv_chan = ch;
        conv_data = d;
        conv_done = vld;
        alarm_clr = clr;
        @(negedge clk);
        conv_done = 1'b0;
        alarm_clr = '0;
    endtask

    // cycles from the current negedge until conv_start is seen high
    task automatic wait_start(output int cycles);
        cycles = 0;
        while (!conv_start && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    initial begin
        int gap;
        do_reset();
        // R1
        check("R1 status", int'(alarm_status), 0);
        check("R1 irq_oe", int'(irq_oe), 0);
        check("R1 start", int'(conv_start), 0);

        irq_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            logic [1:0] ch;
            ch = VECS[v][45:44];
            lo_thr[ch*DW +: DW] = VECS[v][31:20];
            hi_thr[ch*DW +: DW] = VECS[v][19:8];
            present(ch, VECS[v][43:32], 1'b1, VECS[v][7:4]);
            check($sformatf("R4-vector %0d status", v), int'(alarm_status), int'(VECS[v][3:0]));
            check($sformatf("R10 vector %0d irq_oe", v), int'(irq_oe), int'(VECS[v][3:0] != 0));
        end

        // R12: strobe low with a violating value, and a violation on another channel
        lo_thr = {NCH{12'h200}};
        hi_thr = {NCH{12'hE00}};
        present(2'd1, 12'h000, 1'b0, '0);
        check("R12 no strobe", int'(alarm_status), 0);
        present(2'd3, 12'hFFF, 1'b1, '0);
        check("R12 other channel", int'(alarm_status), 8);

        // R11 and R10: latch with interrupts off
        irq_en = 1'b0;
        present(2'd0, 12'h001, 1'b1, 4'h8);
        check("R11 status", int'(alarm_status), 1);
        check("R10 oe off", int'(irq_oe), 0);
        irq_en = 1'b1;
        #1;
        check("R10 oe on", int'(irq_oe), 1);
        check("R10 data low", int'(irq_data), 0);

        // R2 and R3: timing and channel order
        chan_last = 2'd3;
        delay_code = 3'd0;
        do_reset();
        check("R1 after reset", int'(alarm_status), 0);
        wait_start(gap);
        check("R3 first chan", int'(start_chan), 0);
        for (int k = 1; k < 5; k++) begin
            @(negedge clk);
            wait_start(gap);
            check("R2 code0 gap", gap + 1, 8);
            check("R3 chan order", int'(start_chan), k % 4);
        end
        delay_code = 3'd2;
        do_reset();
        wait_start(gap);
        @(negedge clk);
        wait_start(gap);
        check("R2 code2 gap", gap + 1, 32);
        delay_code = 3'd7;
        do_reset();
        wait_start(gap);
        @(negedge clk);
        wait_start(gap);
        check("R2 code7 gap", gap + 1, 1024);

        chan_last = 2'd2;
        delay_code = 3'd0;
        do_reset();
        for (int k = 0; k < 7; k++) begin
            wait_start(gap);
            check("R3 wrap at last", int'(start_chan), k % 3);
            @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule